// File: doc/BRIEF.md
# Banked Register File with Address Translation

This block is the data-memory front end of a small 8-bit controller. The datapath presents a 5-bit register field taken from an instruction. The block resolves that field to one physical byte. It holds an 8-bit bank pointer register and the 136 general-purpose bytes. The pointer register has two roles. Its top three bits choose the bank for upper-half accesses. When the field is zero, the whole register becomes an indirect target address.

The lower sixteen addresses of every bank alias a single shared global region. The upper sixteen are private to each bank. The bank pointer itself lives at address 04h. Dedicated addresses other than 04h are not stored here. They go out on a sideband port, and that port's read data is passed back on the read bus. A separate bank command rewrites the three bank bits alone. Reads are combinational. Writes land on the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset the bank pointer is 00h, so bank 0 is selected, and every general-purpose byte reads 00h.
- R2: Field values 08h–0Fh reach one shared set of eight global bytes, whatever the bank bits hold.
- R3: Field values 10h–1Fh reach the byte at that offset in the bank given by pointer bits [7:5]. Each of the eight banks keeps its own sixteen bytes.
- R4: Field 04h reads the full bank pointer. A write to 04h replaces all eight bits at the next rising edge.
- R5: A bank command loads bank_sel into pointer bits [7:5] and keeps bits [4:0]. If the same cycle also writes the pointer, bits [7:5] come from the command and bits [4:0] come from the write data.
- R6: Field 00h uses the pointer as the target: bits [7:5] give the bank and bits [4:0] give the offset. An offset below 10h resolves to the same global or dedicated target that a direct access would reach, for any bank bits. This includes 04h, which is the pointer itself.
- R7: An indirect access whose pointer offset is 00h reads 00h, changes no state and raises no sideband strobe.
- R8: A resolved offset of 01h–03h or 05h–07h raises side_stb. side_addr then carries the offset's low three bits, side_wdata carries wdata, side_we equals we, and rdata equals side_rdata. At any other offset, side_stb and side_we are low.
- R9: In the cycle of a write, rdata still shows the old content. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fld | input | 5 | Register field from the instruction |
| we | input | 1 | Write enable for the resolved target |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the resolved target |
| bank_we | input | 1 | Bank command strobe |
| bank_sel | input | 3 | Bank number for the bank command |
| side_stb | output | 1 | Access resolves to an external dedicated address |
| side_we | output | 1 | Write to the external dedicated address |
| side_addr | output | 3 | External dedicated address |
| side_wdata | output | 8 | Write data to the external address |
| side_rdata | input | 8 | Read data returned by the external address |

## Verification
A wrong bank pointer shows up at once on the read bus. The very next upper-half or indirect read returns another bank's byte, and a direct read of 04h exposes the pointer in the cycle after the faulty update. An aliasing error in the global region shows on the first cross-bank read of 08h–0Fh. A decode error sends the sideband strobe the wrong way in the same cycle as the access. The bench steps a behavioural model on every clock and compares rdata and all sideband outputs in each cycle. Every error of this kind therefore surfaces within one cycle of the access that reaches it.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int DATA_W  = 8;
    localparam int OFS_W   = 5;
    localparam int BANK_W  = 3;
    localparam int SIDE_W  = 3;
    localparam int NBANKS  = 1 << BANK_W;
    localparam int UPPER_N = 1 << (OFS_W - 1);
    localparam int GLOB_N  = 8;

    localparam logic [OFS_W-1:0] PTR_ADDR = 5'h04;
    localparam logic [OFS_W-1:0] GP_FIRST = 5'h08;

    typedef enum logic [1:0] {
        TGT_NULL,
        TGT_PTR,
        TGT_SIDE,
        TGT_MEM
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e           kind;
        logic [BANK_W-1:0]   bank;
        logic [OFS_W-1:0]    ofs;
    } tgt_t;

    // Map an instruction field plus the bank pointer to a physical target.
    function automatic tgt_t resolve_target(
        input logic [OFS_W-1:0]  fld,
        input logic [DATA_W-1:0] ptr
    );
        tgt_t              t;
        logic [OFS_W-1:0]  o;
        o      = (fld == '0) ? ptr[OFS_W-1:0] : fld;
        t.ofs  = o;
        t.bank = o[OFS_W-1] ? ptr[DATA_W-1 -: BANK_W] : '0;
        if (o == '0)
            t.kind = TGT_NULL;
        else if (o == PTR_ADDR)
            t.kind = TGT_PTR;
        else if (o < GP_FIRST)
            t.kind = TGT_SIDE;
        else
            t.kind = TGT_MEM;
        return t;
    endfunction

endpackage

// File: rtl/brf_xlate.sv
module brf_xlate
    import brf_pkg::*;
(
    input  logic [OFS_W-1:0]  fld,
    input  logic [DATA_W-1:0] ptr,
    output tgt_t              tgt
);

    always_comb begin
        tgt = resolve_target(fld, ptr);
    end

endmodule

// File: rtl/brf_ptr.sv
module brf_ptr
    import brf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          bsel_en,
    input  logic [BW-1:0] bsel,
    output logic [DW-1:0] ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            if (wr_en)
                ptr_q <= wdata;
            // bank command owns the top bits when both happen together
            if (bsel_en)
                ptr_q[DW-1 -: BW] <= bsel;
        end
    end

endmodule

// File: rtl/brf_store.sv
module brf_store
    import brf_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int OW    = OFS_W,
    parameter int BW    = BANK_W,
    parameter int NB    = NBANKS,
    parameter int NUP   = UPPER_N,
    parameter int NGLOB = GLOB_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [BW-1:0] bank,
    input  logic [OW-1:0] ofs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd
);

    localparam int GI_W = $clog2(NGLOB);
    localparam int UI_W = $clog2(NUP);

    logic [GI_W-1:0] g_idx;
    logic [UI_W-1:0] u_idx;
    logic            upper;

    assign g_idx = ofs[GI_W-1:0];
    assign u_idx = ofs[UI_W-1:0];
    assign upper = ofs[OW-1];

    logic [DW-1:0] glob_q [NGLOB];
    logic [DW-1:0] row_rd [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NGLOB; i++)
                glob_q[i] <= '0;
        end else if (wr_en && !upper) begin
            glob_q[g_idx] <= wdata;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [DW-1:0] row_q [NUP];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NUP; i++)
                    row_q[i] <= '0;
            end else if (wr_en && upper && (bank == BW'(b))) begin
                row_q[u_idx] <= wdata;
            end
        end

        assign row_rd[b] = row_q[u_idx];
    end

    assign rd = upper ? row_rd[bank] : glob_q[g_idx];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  fld,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              side_stb,
    output logic              side_we,
    output logic [SIDE_W-1:0] side_addr,
    output logic [DATA_W-1:0] side_wdata,
    input  logic [DATA_W-1:0] side_rdata
);

    logic [DATA_W-1:0] fsr_q;
    logic [DATA_W-1:0] mem_rd;
    tgt_t              tgt;

    brf_xlate i_xlate (
        .fld (fld),
        .ptr (fsr_q),
        .tgt (tgt)
    );

    brf_ptr i_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (we && (tgt.kind == TGT_PTR)),
        .wdata   (wdata),
        .bsel_en (bank_we),
        .bsel    (bank_sel),
        .ptr_q   (fsr_q)
    );

    brf_store i_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (we && (tgt.kind == TGT_MEM)),
        .bank  (tgt.bank),
        .ofs   (tgt.ofs),
        .wdata (wdata),
        .rd    (mem_rd)
    );

    assign side_stb   = (tgt.kind == TGT_SIDE);
    assign side_we    = side_stb && we;
    assign side_addr  = tgt.ofs[SIDE_W-1:0];
    assign side_wdata = wdata;

    always_comb begin
        unique case (tgt.kind)
            TGT_PTR:  rdata = fsr_q;
            TGT_SIDE: rdata = side_rdata;
            TGT_MEM:  rdata = mem_rd;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/brf_chk.sv
module brf_chk
    import brf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  fld,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              bank_we,
    input logic [BANK_W-1:0] bank_sel,
    input logic              side_stb,
    input logic              side_we,
    input logic [SIDE_W-1:0] side_addr,
    input logic [DATA_W-1:0] fsr_q
);

    logic hits_ptr;
    assign hits_ptr = (fld == PTR_ADDR) ||
                      (fld == '0 && fsr_q[OFS_W-1:0] == PTR_ADDR);

    // R1
    ptr_reset_chk: assert property (@(posedge clk) rst |=> fsr_q == '0);

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && fld == PTR_ADDR && !bank_we) |=> fsr_q == $past(wdata));

    // R5
    bank_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_we && !(we && hits_ptr)) |=>
        (fsr_q[DATA_W-1 -: BANK_W] == $past(bank_sel)) &&
        (fsr_q[OFS_W-1:0] == $past(fsr_q[OFS_W-1:0])));

    // R7
    null_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (fld == '0 && fsr_q[OFS_W-1:0] == '0) |-> (rdata == '0 && !side_stb));

    // R8
    side_addr_chk: assert property (@(posedge clk) disable iff (rst)
        side_stb |-> (side_addr != 3'd0 && side_addr != 3'd4));

    // R8
    side_we_chk: assert property (@(posedge clk) disable iff (rst)
        side_we |-> (side_stb && we));

endmodule

bind banked_regfile brf_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .fld       (fld),
    .we        (we),
    .wdata     (wdata),
    .rdata     (rdata),
    .bank_we   (bank_we),
    .bank_sel  (bank_sel),
    .side_stb  (side_stb),
    .side_we   (side_we),
    .side_addr (side_addr),
    .fsr_q     (fsr_q)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] fld = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bank_we = 1'b0;
    logic [2:0] bank_sel = '0;
    logic       side_stb;
    logic       side_we;
    logic [2:0] side_addr;
    logic [7:0] side_wdata;
    logic [7:0] side_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model: flat 256-byte space keyed by canonical address, plus pointer
    logic [7:0] m_mem [256];
    logic [7:0] m_ptr;

    always #5 clk = ~clk;

    assign side_rdata = 8'hC0 | {5'b0, side_addr};

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .fld(fld), .we(we), .wdata(wdata),
        .rdata(rdata), .bank_we(bank_we), .bank_sel(bank_sel),
        .side_stb(side_stb), .side_we(side_we), .side_addr(side_addr),
        .side_wdata(side_wdata), .side_rdata(side_rdata)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] f, input logic w, input logic [7:0] d,
                        input logic bw, input logic [2:0] bs, input string tag);
        logic [7:0] addr;
        int         kind;   // 0 null, 1 pointer, 2 external, 3 byte
        int         key;
        int         exp_rd;
        @(negedge clk);
        fld = f; we = w; wdata = d; bank_we = bw; bank_sel = bs;
        #1;
        addr = (f == 5'd0) ? m_ptr : {m_ptr[7:5], f};
        if (addr[4:0] == 5'd0)      kind = 0;
        else if (addr[4:0] == 5'd4) kind = 1;
        else if (addr[4:0] < 5'd8)  kind = 2;
        else                        kind = 3;
        key = (addr[4:0] < 5'h10) ? int'(addr[4:0]) : int'(addr);
        case (kind)
            0: exp_rd = 0;
            1: exp_rd = m_ptr;
            2: exp_rd = 8'hC0 | addr[2:0];
            default: exp_rd = m_mem[key];
        endcase
        check(rdata, exp_rd, tag, "rdata");
        check(side_stb, kind == 2, tag, "side_stb");
        check(side_we, (kind == 2) && w, tag, "side_we");
        if (kind == 2) begin
            check(side_addr, addr[2:0], tag, "side_addr");
            check(side_wdata, d, tag, "side_wdata");
        end
        @(posedge clk);
        if (w && kind == 3) m_mem[key] = d;
        if (w && kind == 1) m_ptr = d;
        if (bw) m_ptr[7:5] = bs;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_ptr = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        step(5'h04, 0, 8'h00, 0, 3'd0, "R1");
        step(5'h08, 0, 8'h00, 0, 3'd0, "R1");
        step(5'h1F, 0, 8'h00, 0, 3'd0, "R1");

        // R2: global bytes alias across banks
        step(5'h08, 1, 8'h11, 0, 3'd0, "R2");
        step(5'h0F, 1, 8'h22, 1, 3'd3, "R2");
        step(5'h08, 0, 8'h00, 0, 3'd0, "R2");
        step(5'h0F, 0, 8'h00, 1, 3'd6, "R2");
        step(5'h0F, 0, 8'h00, 0, 3'd0, "R2");

        // R3: private upper halves
        for (int b = 0; b < 8; b++) begin
            step(5'h10, 0, 8'h00, 1, 3'(b), "R3");
            step(5'h10, 1, 8'(b * 16 + 1), 0, 3'd0, "R3");
            step(5'h1F, 1, 8'(b * 16 + 15), 0, 3'd0, "R3");
        end
        for (int b = 7; b >= 0; b--) begin
            step(5'h10, 0, 8'h00, 1, 3'(b), "R3");
            step(5'h10, 0, 8'h00, 0, 3'd0, "R3");
            step(5'h1F, 0, 8'h00, 0, 3'd0, "R3");
        end

        // R4 / R5: pointer writes and bank command
        step(5'h04, 1, 8'h6A, 0, 3'd0, "R4");
        step(5'h04, 0, 8'h00, 0, 3'd0, "R4");
        step(5'h04, 0, 8'h00, 1, 3'd2, "R5");
        step(5'h04, 0, 8'h00, 0, 3'd0, "R5");
        step(5'h04, 1, 8'h1F, 1, 3'd5, "R5");
        step(5'h04, 0, 8'h00, 0, 3'd0, "R5");

        // R6: indirect
        step(5'h04, 1, {3'd5, 5'h12}, 0, 3'd0, "R6");
        step(5'h00, 0, 8'h00, 0, 3'd0, "R6");
        step(5'h00, 1, 8'h9C, 0, 3'd0, "R6");
        step(5'h12, 0, 8'h00, 0, 3'd0, "R6");
        step(5'h04, 1, {3'd7, 5'h09}, 0, 3'd0, "R6");
        step(5'h00, 1, 8'h3E, 0, 3'd0, "R6");
        step(5'h09, 0, 8'h00, 1, 3'd1, "R6");
        step(5'h04, 1, {3'd2, 5'h04}, 0, 3'd0, "R6");
        step(5'h00, 0, 8'h00, 0, 3'd0, "R6");
        step(5'h00, 1, {3'd3, 5'h1A}, 0, 3'd0, "R6");
        step(5'h00, 0, 8'h00, 0, 3'd0, "R6");

        // R7: null pointer
        step(5'h04, 1, {3'd6, 5'h00}, 0, 3'd0, "R7");
        step(5'h00, 1, 8'hFF, 0, 3'd0, "R7");
        step(5'h00, 0, 8'h00, 0, 3'd0, "R7");
        step(5'h04, 0, 8'h00, 0, 3'd0, "R7");

        // R8: sideband forwarding, direct and indirect
        step(5'h01, 1, 8'hA1, 0, 3'd0, "R8");
        step(5'h02, 0, 8'hA2, 0, 3'd0, "R8");
        step(5'h03, 1, 8'hA3, 0, 3'd0, "R8");
        step(5'h05, 1, 8'hA5, 0, 3'd0, "R8");
        step(5'h06, 0, 8'hA6, 0, 3'd0, "R8");
        step(5'h07, 1, 8'hA7, 0, 3'd0, "R8");
        step(5'h04, 1, {3'd4, 5'h03}, 0, 3'd0, "R8");
        step(5'h00, 1, 8'h5D, 0, 3'd0, "R8");

        // R9: write-cycle read shows old value
        step(5'h0C, 1, 8'h77, 0, 3'd0, "R9");
        step(5'h0C, 1, 8'h88, 0, 3'd0, "R9");
        step(5'h0C, 0, 8'h00, 0, 3'd0, "R9");

        // mixed traffic, checked against the model every cycle (R3, R6, R8)
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[4:0], lf[5], lf[15:8], lf[6] & lf[7], lf[10:8], "R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule